// File: doc/BRIEF.md
# Indirect Pattern RAM Access Port

This block holds a 64-entry table of 40-bit pattern words and gives host software access to it through three 16-bit registers. The host first writes the control register, which selects a word address and sets or clears the match-enable mode. The addressed word can then be read through the three registers in any order. A write is staged: the control write carries byte 0, the middle register write carries bytes 1 and 2, and only a following upper register write carries bytes 3 and 4 and commits the complete word in one memory write.

While the match-enable mode is set, the table belongs to a pattern matching engine. Host reads of the pattern data then return zero and host writes are dropped. The engine itself sits outside this block and sees only a registered read port. The table is not cleared by reset, so its contents survive any reset that follows power-up.

Top module: `patram_port`

## Requirements
- R1: After reset, match mode is 0, the selected address is 0, `hst_rvalid` is 0, `hst_rdata` is 0 and no write is staged.
- R2: Register select 0 (control) holds the word address in bits 6:0, the match mode in bit 7 and byte 0 (word bits 7:0) in bits 15:8. A read returns the stored address and mode, with byte 0 taken from the addressed word.
- R3: Register select 1 holds word byte 1 in bits 7:0 and byte 2 in bits 15:8. Register select 2 holds byte 3 in bits 7:0 and byte 4 in bits 15:8.
- R4: The three registers may be read in any order. The data for a read sampled at a clock edge appears with `hst_rvalid` high two edges later, and `hst_rvalid` is high in no other cycle.
- R5: Writing the control register never changes the table.
- R6: The table is written only by a select-2 write that follows a select-1 write, which itself follows a select-0 write. The word written is {select-2 data, select-1 data, byte 0 from the control write}, and a read issued on the next cycle returns it.
- R7: A select-2 write with no select-1 write since the last control write is ignored. A select-1 write with no control write since the last commit is ignored.
- R8: While match mode is 1, data read from selects 1 and 2 and from bits 15:8 of select 0 is zero, and writes to selects 1 and 2 are discarded.
- R9: For an address at or above the table depth (64), data fields read as zero and commits are discarded.
- R10: Reset leaves the table contents unchanged.
- R11: The matching read port returns the word at `mt_addr` one clock edge after that address is applied.
- R12: Select 3 ignores writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host register write strobe |
| hst_re | input | 1 | Host register read strobe |
| hst_sel | input | 2 | Register select (0 control, 1 middle, 2 upper, 3 unused) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, registered |
| hst_rvalid | output | 1 | Read data valid |
| match_en | output | 1 | Match-enable mode, hands the table to the matching engine |
| mt_addr | input | 6 | Matching engine read address |
| mt_data | output | 40 | Matching engine read data, registered |

## Verification
A host read is due exactly two edges after its strobe is sampled: one edge to read the RAM and latch the select, and one edge for the output register. The driver records the cycle count at issue plus two with every expected value, and the monitor samples at the falling edge and fails any response that is early, late, missing or unexpected. A commit or address change is visible to a read issued on the very next cycle. The matching port is checked one edge after its address is set.

// File: rtl/patram_pkg.sv
package patram_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 40;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MID  = 2'd1;
  localparam logic [1:0] SEL_UPR  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MID   = 2'd2
  } stage_t;
endpackage

// File: rtl/patram_store.sv
module patram_store #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 40,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic [IDX_W-1:0] b_addr,
  output logic [WIDTH-1:0] b_rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/patram_stager.sv
module patram_stager
  import patram_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [ADDR_W-1:0] addr,
  output logic              mode,
  output logic              oor,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  stage_t      state;
  logic [7:0]  byte0;
  logic [15:0] mid;

  assign oor    = ({25'd0, addr} >= DEPTH);
  assign commit = we && (sel == SEL_UPR) && !mode && (state == ST_MID) && !oor;
  assign word   = {wdata, mid, byte0};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      addr  <= '0;
      mode  <= 1'b0;
      byte0 <= '0;
      mid   <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: begin
          addr  <= wdata[ADDR_W-1:0];
          mode  <= wdata[7];
          byte0 <= wdata[15:8];
          state <= wdata[7] ? ST_IDLE : ST_ARMED;
        end
        SEL_MID: begin
          if (!mode && state != ST_IDLE) begin
            mid   <= wdata;
            state <= ST_MID;
          end
        end
        SEL_UPR: begin
          if (!mode && state == ST_MID) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/patram_rdmux.sv
module patram_rdmux
  import patram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode,
  input  logic              oor,
  input  logic [WORD_W-1:0] word,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid
);
  logic              pend_q;
  logic [1:0]        sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mode_q;
  logic              lock_q;
  logic [REG_W-1:0]  pick;

  always_comb begin
    case (sel_q)
      SEL_CTRL: pick = {lock_q ? 8'h00 : word[7:0], mode_q, addr_q};
      SEL_MID:  pick = lock_q ? '0 : word[23:8];
      SEL_UPR:  pick = lock_q ? '0 : word[39:24];
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      addr_q <= '0;
      mode_q <= 1'b0;
      lock_q <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      pend_q <= re;
      if (re) begin
        sel_q  <= sel;
        addr_q <= addr;
        mode_q <= mode;
        lock_q <= mode | oor;
      end
      rvalid <= pend_q;
      if (pend_q) rdata <= pick;
    end
  end
endmodule

// File: rtl/patram_port.sv
module patram_port
  import patram_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_we,
  input  logic              hst_re,
  input  logic [1:0]        hst_sel,
  input  logic [REG_W-1:0]  hst_wdata,
  output logic [REG_W-1:0]  hst_rdata,
  output logic              hst_rvalid,
  output logic              match_en,
  input  logic [IDX_W-1:0]  mt_addr,
  output logic [WORD_W-1:0] mt_data
);
  logic [ADDR_W-1:0] sel_addr;
  logic              oor;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] host_word;

  patram_stager #(.DEPTH(DEPTH)) u_stager (
    .clk(clk), .rst(rst), .we(hst_we), .sel(hst_sel), .wdata(hst_wdata),
    .addr(sel_addr), .mode(match_en), .oor(oor),
    .commit(commit), .word(commit_word)
  );

  patram_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
    .clk(clk), .a_we(commit), .a_addr(sel_addr[IDX_W-1:0]),
    .a_wdata(commit_word), .a_rdata(host_word),
    .b_addr(mt_addr), .b_rdata(mt_data)
  );

  patram_rdmux u_rdmux (
    .clk(clk), .rst(rst), .re(hst_re), .sel(hst_sel), .addr(sel_addr),
    .mode(match_en), .oor(oor), .word(host_word),
    .rdata(hst_rdata), .rvalid(hst_rvalid)
  );
endmodule

// File: rtl/patram_port_chk.sv
module patram_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        hst_we,
  input logic        hst_re,
  input logic [1:0]  hst_sel,
  input logic [15:0] hst_rdata,
  input logic        hst_rvalid,
  input logic        match_en,
  input logic        commit
);
  // R4
  rd_due_chk: assert property (@(posedge clk) disable iff (rst)
    hst_re |-> ##2 hst_rvalid);
  // R4
  rd_only_chk: assert property (@(posedge clk) disable iff (rst)
    hst_rvalid |-> $past(hst_re, 2));
  // R5
  ctrl_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_we && hst_sel == 2'd0) |-> !commit);
  // R6
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> (hst_we && hst_sel == 2'd2));
  // R8
  locked_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    match_en |-> !commit);
  // R8
  locked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_rvalid && $past(match_en, 2) && ($past(hst_sel, 2) != 2'd0)) |-> (hst_rdata == 16'd0));
  // R12
  badsel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_rvalid && $past(hst_sel, 2) == 2'd3) |-> (hst_rdata == 16'd0));
endmodule

bind patram_port patram_port_chk u_chk (
  .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_sel(hst_sel),
  .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .match_en(match_en),
  .commit(commit)
);

// File: tb/patram_port_bench.sv
module patram_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_we = 1'b0;
  logic        hst_re = 1'b0;
  logic [1:0]  hst_sel = 2'd0;
  logic [15:0] hst_wdata = 16'd0;
  logic [15:0] hst_rdata;
  logic        hst_rvalid;
  logic        match_en;
  logic [5:0]  mt_addr = 6'd0;
  logic [39:0] mt_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [15:0] d;
    int          due;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [39:0] bm [64];

  patram_port u_patram_port (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .match_en(match_en), .mt_addr(mt_addr), .mt_data(mt_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_sel = s; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [15:0] e, input string tag);
    @(negedge clk);
    hst_re = 1'b1; hst_sel = s;
    sbq.push_back('{d: e, due: cyc + 2, tag: tag});
    @(negedge clk);
    hst_re = 1'b0;
  endtask

  task automatic wrword(input logic [6:0] a, input logic [39:0] w);
    wr(2'd0, {w[7:0], 1'b0, a});
    wr(2'd1, w[23:8]);
    wr(2'd2, w[39:24]);
    if (a < 7'd64) bm[a[5:0]] = w;
  endtask

  task automatic drain;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (hst_rvalid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R4 unexpected rvalid", {24'd0, hst_rdata}, 40'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(cyc == e.due, {e.tag, " timing"}, cyc, e.due);
          check(hst_rdata == e.d, e.tag, {24'd0, hst_rdata}, {24'd0, e.d});
        end
      end else if (sbq.size() != 0 && sbq[0].due < cyc) begin
        exp_t e;
        e = sbq.pop_front();
        check(1'b0, {e.tag, " missing rvalid"}, cyc, e.due);
      end
    end
  end

  initial begin
    #(5 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(hst_rvalid == 1'b0, "R1 rvalid", hst_rvalid, 0);
    check(match_en == 1'b0, "R1 match mode", match_en, 0);
    check(hst_rdata == 16'd0, "R1 rdata", hst_rdata, 0);

    // R2 R3 R6 write then read in mixed order
    wrword(7'd5, 40'hA4A3A2A1A0);
    rd(2'd2, 16'hA4A3, "R3 upper");
    rd(2'd0, 16'hA005, "R2 ctrl");
    rd(2'd1, 16'hA2A1, "R4 middle");
    wrword(7'd6, 40'h5453525150);
    rd(2'd0, 16'h5006, "R6 commit b0");
    rd(2'd2, 16'h5453, "R6 commit upper");

    // R5 control write alone leaves table
    wr(2'd0, {8'hEE, 1'b0, 7'd5});
    rd(2'd0, 16'hA005, "R5 ctrl only");
    rd(2'd2, 16'hA4A3, "R5 upper kept");

    // R7 upper without middle ignored, then proper order commits
    wr(2'd0, {8'h11, 1'b0, 7'd6});
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h5453, "R7 lone upper");
    wr(2'd1, 16'h2222);
    wr(2'd2, 16'h3333);
    bm[6] = 40'h3333222211;
    rd(2'd0, 16'h1106, "R6 reorder b0");
    rd(2'd1, 16'h2222, "R6 reorder mid");
    rd(2'd2, 16'h3333, "R6 reorder upper");
    // R7 middle after commit without control write
    wr(2'd1, 16'h7777);
    wr(2'd2, 16'h8888);
    rd(2'd1, 16'h2222, "R7 stale middle");
    rd(2'd2, 16'h3333, "R7 stale upper");

    // R8 match mode locks the table
    wr(2'd0, {8'h00, 1'b1, 7'd6});
    check(match_en == 1'b1, "R8 match_en", match_en, 1);
    rd(2'd0, 16'h0086, "R8 ctrl locked");
    rd(2'd1, 16'h0000, "R8 mid locked");
    rd(2'd2, 16'h0000, "R8 upper locked");
    wr(2'd1, 16'h9999);
    wr(2'd2, 16'hAAAA);
    wr(2'd0, {8'h00, 1'b0, 7'd6});
    rd(2'd1, 16'h2222, "R8 mid unchanged");
    rd(2'd2, 16'h3333, "R8 upper unchanged");

    // R9 out of range address
    wrword(7'd70, 40'hCCCCBBBBAA);
    rd(2'd0, 16'h0046, "R9 ctrl oor");
    rd(2'd1, 16'h0000, "R9 mid oor");
    wr(2'd0, {8'h00, 1'b0, 7'd6});
    rd(2'd2, 16'h3333, "R9 alias kept");

    // R12 unused select
    wr(2'd3, 16'h5A5A);
    rd(2'd3, 16'h0000, "R12 read zero");
    rd(2'd1, 16'h2222, "R12 no write");

    // boundary addresses
    wrword(7'd0, 40'h0403020100);
    wrword(7'd63, 40'hF4F3F2F1F0);
    rd(2'd0, 16'hF03F, "R2 addr 63");
    rd(2'd2, 16'hF4F3, "R3 addr 63");
    wr(2'd0, {8'h00, 1'b0, 7'd0});
    rd(2'd1, 16'h0201, "R3 addr 0");
    drain();

    // R10 reset keeps table
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(hst_rvalid == 1'b0, "R1 rvalid after reset", hst_rvalid, 0);
    check(match_en == 1'b0, "R1 mode after reset", match_en, 0);
    rd(2'd0, 16'h0000, "R1 addr zero");
    wr(2'd0, {8'h00, 1'b0, 7'd5});
    rd(2'd1, 16'hA2A1, "R10 word kept");
    rd(2'd2, 16'hA4A3, "R10 upper kept");
    drain();

    // R11 matching read port
    foreach (bm[i]) begin
      if (i == 0 || i == 5 || i == 6 || i == 63) begin
        @(negedge clk); mt_addr = 6'(i);
        @(negedge clk);
        check(mt_data == bm[i], "R11 match port", mt_data, bm[i]);
      end
    end

    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule